// File: doc/BRIEF.md
# Variable-Page-Size Translation Lookaside Buffer

This block is a fully associative translation buffer with 64 entries, filled by software. It maps a 32-bit virtual address to a physical address. Each entry holds a tag word, a data word and an 8-bit translation ID. The tag word carries a page-size code, so a page can be anywhere from 1 KB to 16 MB in steps of four. The compare mask and the translate mask therefore differ from one entry to the next.

Software programs the buffer through a small register port with a 3-bit register select. Select 0 is the process ID. Select 1 is the zone-protection word. Select 2 is the entry index. Select 3 is the data (low) word of the indexed entry. Select 4 is the tag (high) word of the indexed entry. Select 5 is the associative search.

A lookup presents a virtual address, an access kind and a user/supervisor flag. One clock later the block returns a registered result: the outcome, the physical address, the index of the matching entry, and the effective protection bits.

Top module: `vpage_tlb`

## Requirements
- R1: After reset every entry is invalid and the process ID, zone, index and result registers read zero. A lookup made straight after reset reports a miss.
- R2: A write to select 4 stores the tag word at the entry named by index bits 5:0, and latches process ID bits 7:0 as that entry's translation ID. A write to select 3 stores the data word at the same entry. A read of select 3 returns the indexed entry's data word, and a read of select 4 returns its tag word.
- R3: Tag bit 6 marks the entry valid. Tag bits 9:7 hold a size code c, which gives an offset of 10+2c bits. Only address bits from 10+2c up to 31 are compared with the tag, and the page number sits in tag bits 31:10.
- R4: An entry matches only when its translation ID equals process ID bits 7:0, or when its translation ID is 0.
- R5: When several entries match, the lowest index is reported and used.
- R6: res_status reports exactly one outcome: 0 for hit, 1 for miss (no valid matching entry), 2 for protection fault (an entry matches but the access is refused). It never takes the value 3.
- R7: Access kinds are coded 0 for read, 1 for write and 2 for fetch. Data bit 9 permits fetch and data bit 8 permits write. A read is allowed unless a zone rule denies it.
- R8: Data bits 7:4 hold the zone number z. The zone field is zone-word bits [31-2z:30-2z]. In user mode, field 0 denies every access and field 3 grants every access. Fields 1 and 2 leave the entry bits in force.
- R9: In supervisor mode, zone field 2 or 3 grants every access. Fields 0 and 1 leave the entry bits in force.
- R10: A write of an address to select 5 loads the index register with the lowest matching entry, using the same match rules as a lookup. On a miss it loads 0x8000_0000.
- R11: res_valid is high for exactly the one cycle after each cycle with lk_valid high. The result fields are valid in that cycle.
- R12: On a hit or a fault, res_paddr takes its bits above the page offset from data bits 31:10 and its offset bits from the virtual address. res_idx is the entry number. res_prot is {fetch allowed, write allowed} after the zone rules. On a miss, all three are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0..5) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational read of the selected register |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| lk_user | input | 1 | 1 for user mode, 0 for supervisor mode |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_status | output | 2 | 0 hit, 1 miss, 2 protection fault |
| res_paddr | output | 32 | Translated physical address |
| res_idx | output | 6 (IDX_W) | Index of the matching entry |
| res_prot | output | 2 | {fetch allowed, write allowed} |

## Verification
The assertions assume that lk_kind stays within codes 0 to 2 while a request is made. They also assume that cfg_sel only names registers 0 to 5 when cfg_wr is high. The permission checks rely on lk_kind of the previous cycle being the kind of the reported lookup. The bench only ever issues the three defined kinds and the six defined selects.

Entry pages are placed at disjoint 16 MB-aligned bases, so overlaps happen only where the priority cases put them there on purpose. The bench changes the process ID and zone word only between lookups, never in the same cycle as a request.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        ST_HIT  = 2'd0,
        ST_MISS = 2'd1,
        ST_PROT = 2'd2
    } tlb_status_e;

    localparam logic [1:0] AK_READ  = 2'd0;
    localparam logic [1:0] AK_WRITE = 2'd1;
    localparam logic [1:0] AK_FETCH = 2'd2;

    localparam logic [2:0] RS_PID    = 3'd0;
    localparam logic [2:0] RS_ZONE   = 3'd1;
    localparam logic [2:0] RS_INDEX  = 3'd2;
    localparam logic [2:0] RS_LOW    = 3'd3;
    localparam logic [2:0] RS_HIGH   = 3'd4;
    localparam logic [2:0] RS_SEARCH = 3'd5;

    localparam logic [31:0] SEARCH_MISS = 32'h8000_0000;

    // Keeps the address bits above the page offset of a size code.
    function automatic logic [31:0] page_mask(input logic [2:0] code);
        page_mask = 32'hFFFF_FFFF << (5'd10 + {1'b0, code, 1'b0});
    endfunction
endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match (
    input  logic [31:0] tag,
    input  logic [7:0]  tid,
    input  logic [7:0]  pid,
    input  logic [31:0] va,
    output logic        hit
);
    import tlb_pkg::*;

    logic [31:0] mask;
    logic        tid_ok;

    always_comb begin
        mask   = page_mask(tag[9:7]);
        tid_ok = (tid == 8'd0) || (tid == pid);
        hit    = tag[6] && tid_ok && ((tag & mask) == (va & mask));
    end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int N     = 64,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0]     hits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |hits;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm (
    input  logic        ex_bit,
    input  logic        wr_bit,
    input  logic [3:0]  zsel,
    input  logic [31:0] zone_word,
    input  logic [1:0]  kind,
    input  logic        user,
    output logic        x_ok,
    output logic        w_ok,
    output logic        allow
);
    import tlb_pkg::*;

    logic [4:0] shamt;
    logic [1:0] zf;
    logic       r_ok;

    always_comb begin
        shamt = 5'd30 - {zsel, 1'b0};
        zf    = 2'(zone_word >> shamt);
        r_ok  = 1'b1;
        x_ok  = ex_bit;
        w_ok  = wr_bit;
        if (user) begin
            if (zf == 2'd0) begin
                r_ok = 1'b0;
                x_ok = 1'b0;
                w_ok = 1'b0;
            end else if (zf == 2'd3) begin
                x_ok = 1'b1;
                w_ok = 1'b1;
            end
        end else if (zf[1]) begin
            x_ok = 1'b1;
            w_ok = 1'b1;
        end
        case (kind)
            AK_WRITE: allow = w_ok;
            AK_FETCH: allow = x_ok;
            default:  allow = r_ok;
        endcase
    end
endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb #(
    parameter int ENTRIES = 64,
    parameter int TID_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [2:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             lk_valid,
    input  logic [31:0]      lk_vaddr,
    input  logic [1:0]       lk_kind,
    input  logic             lk_user,
    output logic             res_valid,
    output logic [1:0]       res_status,
    output logic [31:0]      res_paddr,
    output logic [IDX_W-1:0] res_idx,
    output logic [1:0]       res_prot
);
    import tlb_pkg::*;

    typedef struct packed {
        logic [31:0]      pid;
        logic [31:0]      zone;
        logic [31:0]      index;
        logic             rvalid;
        logic [1:0]       rstatus;
        logic [31:0]      rpaddr;
        logic [IDX_W-1:0] ridx;
        logic [1:0]       rprot;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic [31:0]      tag_d [ENTRIES];
    logic [31:0]      tag_q [ENTRIES];
    logic [31:0]      data_d[ENTRIES];
    logic [31:0]      data_q[ENTRIES];
    logic [TID_W-1:0] tid_d [ENTRIES];
    logic [TID_W-1:0] tid_q [ENTRIES];

    logic [ENTRIES-1:0] lk_hits, sr_hits;
    logic               lk_any, sr_any;
    logic [IDX_W-1:0]   lk_idx, sr_idx;
    logic [IDX_W-1:0]   sel_ent;
    logic               x_ok, w_ok, allow;
    logic [31:0]        hit_mask;
    logic [31:0]        index_now;

    assign sel_ent   = ctl_q.index[IDX_W-1:0];
    assign index_now = ctl_q.index;

    // Two compare banks: one for lookups, one for the search register.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_bank
        tlb_entry_match u_lk (
            .tag(tag_q[g]), .tid(tid_q[g]), .pid(ctl_q.pid[TID_W-1:0]),
            .va(lk_vaddr), .hit(lk_hits[g])
        );
        tlb_entry_match u_sr (
            .tag(tag_q[g]), .tid(tid_q[g]), .pid(ctl_q.pid[TID_W-1:0]),
            .va(cfg_wdata), .hit(sr_hits[g])
        );
    end

    tlb_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_lk_pick (
        .hits(lk_hits), .any(lk_any), .idx(lk_idx)
    );
    tlb_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_sr_pick (
        .hits(sr_hits), .any(sr_any), .idx(sr_idx)
    );

    tlb_perm u_perm (
        .ex_bit(data_q[lk_idx][9]), .wr_bit(data_q[lk_idx][8]),
        .zsel(data_q[lk_idx][7:4]), .zone_word(ctl_q.zone),
        .kind(lk_kind), .user(lk_user),
        .x_ok(x_ok), .w_ok(w_ok), .allow(allow)
    );

    always_comb begin
        ctl_d    = ctl_q;
        tag_d    = tag_q;
        data_d   = data_q;
        tid_d    = tid_q;
        hit_mask = page_mask(tag_q[lk_idx][9:7]);

        ctl_d.rvalid = lk_valid;
        if (lk_valid) begin
            if (!lk_any) begin
                ctl_d.rstatus = ST_MISS;
                ctl_d.rpaddr  = '0;
                ctl_d.ridx    = '0;
                ctl_d.rprot   = '0;
            end else begin
                ctl_d.rstatus = allow ? ST_HIT : ST_PROT;
                ctl_d.rpaddr  = (data_q[lk_idx] & hit_mask) | (lk_vaddr & ~hit_mask);
                ctl_d.ridx    = lk_idx;
                ctl_d.rprot   = {x_ok, w_ok};
            end
        end

        if (cfg_wr) begin
            case (cfg_sel)
                RS_PID:   ctl_d.pid   = cfg_wdata;
                RS_ZONE:  ctl_d.zone  = cfg_wdata;
                RS_INDEX: ctl_d.index = cfg_wdata;
                RS_LOW:   data_d[sel_ent] = cfg_wdata;
                RS_HIGH: begin
                    tag_d[sel_ent] = cfg_wdata;
                    tid_d[sel_ent] = ctl_q.pid[TID_W-1:0];
                end
                RS_SEARCH: ctl_d.index = sr_any ? 32'(sr_idx) : SEARCH_MISS;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i]  <= '0;
                data_q[i] <= '0;
                tid_q[i]  <= '0;
            end
        end else begin
            ctl_q  <= ctl_d;
            tag_q  <= tag_d;
            data_q <= data_d;
            tid_q  <= tid_d;
        end
    end

    always_comb begin
        case (cfg_sel)
            RS_PID:                cfg_rdata = ctl_q.pid;
            RS_ZONE:               cfg_rdata = ctl_q.zone;
            RS_INDEX, RS_SEARCH:   cfg_rdata = ctl_q.index;
            RS_LOW:                cfg_rdata = data_q[sel_ent];
            RS_HIGH:               cfg_rdata = tag_q[sel_ent];
            default:               cfg_rdata = '0;
        endcase
    end

    assign res_valid  = ctl_q.rvalid;
    assign res_status = ctl_q.rstatus;
    assign res_paddr  = ctl_q.rpaddr;
    assign res_idx    = ctl_q.ridx;
    assign res_prot   = ctl_q.rprot;
endmodule

// File: rtl/tlb_checks.sv
module tlb_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic [1:0]  lk_kind,
    input logic        cfg_wr,
    input logic [2:0]  cfg_sel,
    input logic        lk_any,
    input logic        sr_any,
    input logic [31:0] index_now,
    input logic        res_valid,
    input logic [1:0]  res_status,
    input logic [1:0]  res_prot
);
    p_result_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);
    p_no_stray_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);
    p_legal_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_status != 2'd3);
    p_miss_when_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !lk_any |=> res_status == 2'd1);
    p_hit_when_some_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && lk_any |=> res_status != 2'd1);
    p_write_needs_perm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_status == 2'd0 && $past(lk_kind) == 2'd1 |-> res_prot[0]);
    p_fetch_needs_perm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_status == 2'd0 && $past(lk_kind) == 2'd2 |-> res_prot[1]);
    p_search_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_sel == 3'd5 && !sr_any |=> index_now == 32'h8000_0000);
    p_search_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_sel == 3'd5 && sr_any |=> !index_now[31]);
endmodule

bind vpage_tlb tlb_checks u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_kind(lk_kind),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .lk_any(lk_any), .sr_any(sr_any),
    .index_now(index_now), .res_valid(res_valid), .res_status(res_status),
    .res_prot(res_prot)
);

// File: tb/sim_vpage_tlb.sv
`timescale 1ns/1ps
module sim_vpage_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_kind = '0;
    logic        lk_user = 1'b0;
    logic        res_valid;
    logic [1:0]  res_status;
    logic [31:0] res_paddr;
    logic [5:0]  res_idx;
    logic [1:0]  res_prot;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Bench-side picture of the programmed state.
    logic [31:0] m_tag [64];
    logic [31:0] m_dat [64];
    logic [7:0]  m_tid [64];
    logic [31:0] m_pid = '0, m_zone = '0, m_idx = '0;

    always #2.5 clk = ~clk;

    vpage_tlb u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic bit m_match(int e, logic [31:0] va);
        int sh = 10 + 2 * int'(m_tag[e][9:7]);
        return m_tag[e][6] && (m_tid[e] == 8'd0 || m_tid[e] == m_pid[7:0])
               && ((m_tag[e] ^ va) >> sh) == 32'd0;
    endfunction

    function automatic int m_first(logic [31:0] va);
        for (int e = 0; e < 64; e++) if (m_match(e, va)) return e;
        return -1;
    endfunction

    task automatic wr(logic [2:0] sel, logic [31:0] val);
        int f;
        case (sel)
            3'd0: m_pid = val;
            3'd1: m_zone = val;
            3'd2: m_idx = val;
            3'd3: m_dat[m_idx[5:0]] = val;
            3'd4: begin m_tag[m_idx[5:0]] = val; m_tid[m_idx[5:0]] = m_pid[7:0]; end
            default: begin
                f = m_first(val);
                m_idx = (f < 0) ? 32'h8000_0000 : 32'(f);
            end
        endcase
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic put(int e, logic [31:0] tag, logic [31:0] dat);
        wr(3'd2, 32'(e));
        wr(3'd4, tag);
        wr(3'd3, dat);
    endtask

    task automatic look(string req, logic [31:0] va, logic [1:0] kind, logic user);
        int f, sh, zf;
        logic [31:0] e_pa;
        logic [1:0]  e_st, e_pr;
        logic [5:0]  e_ix;
        bit xo, wo, ro, ok;
        f = m_first(va);
        if (f < 0) begin
            e_st = 2'd1; e_pa = '0; e_ix = '0; e_pr = '0;
        end else begin
            sh = 10 + 2 * int'(m_tag[f][9:7]);
            e_pa = ((m_dat[f] >> sh) << sh) | (va - ((va >> sh) << sh));
            e_ix = 6'(f);
            zf = int'((m_zone >> (30 - 2 * int'(m_dat[f][7:4]))) & 32'd3);
            xo = m_dat[f][9]; wo = m_dat[f][8]; ro = 1'b1;
            if (user && zf == 0) begin xo = 0; wo = 0; ro = 0; end
            else if ((user && zf == 3) || (!user && zf >= 2)) begin xo = 1; wo = 1; end
            ok = (kind == 2'd1) ? wo : (kind == 2'd2) ? xo : ro;
            e_st = ok ? 2'd0 : 2'd2;
            e_pr = {xo, wo};
        end
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_kind = kind; lk_user = user;
        @(negedge clk);
        lk_valid = 1'b0;
        check({req, " R11 valid"}, 32'(res_valid), 32'd1);
        check({req, " R6 status"}, 32'(res_status), 32'(e_st));
        check({req, " R12 paddr"}, res_paddr, e_pa);
        check({req, " R12 idx"}, 32'(res_idx), 32'(e_ix));
        check({req, " R12 prot"}, 32'(res_prot), 32'(e_pr));
        @(negedge clk);
        check({req, " R11 pulse"}, 32'(res_valid), 32'd0);
    endtask

    initial begin
        for (int e = 0; e < 64; e++) begin m_tag[e] = '0; m_dat[e] = '0; m_tid[e] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 res_valid", 32'(res_valid), 32'd0);
        for (int s = 0; s < 6; s++) begin
            cfg_sel = 3'(s); #0.1;
            check("R1 reg zero", cfg_rdata, 32'd0);
        end
        look("R1 reset miss", 32'h1234_5678, 2'd0, 1'b0);

        // R2 readback and layout
        put(7, 32'hABCD_E440, 32'h1357_9B30);
        cfg_sel = 3'd4; #0.1; check("R2 tag read", cfg_rdata, 32'hABCD_E440);
        cfg_sel = 3'd3; #0.1; check("R2 data read", cfg_rdata, 32'h1357_9B30);
        put(7, 32'h0, 32'h0);

        // R3 page sizes: entry c at base (c+1)<<24, every size code
        wr(3'd1, 32'hFFFF_FFFF);
        for (int c = 0; c < 8; c++) begin
            put(c, (32'(c + 1) << 24) | (32'(c) << 7) | 32'h40,
                32'h8000_0000 + (32'(c) << 24) + 32'h0300);
        end
        for (int c = 0; c < 8; c++) begin
            logic [31:0] base = 32'(c + 1) << 24;
            int sz = 1 << (10 + 2 * c);
            look("R3 first", base, 2'd0, 1'b1);
            look("R3 last", base + 32'(sz - 1), 2'd1, 1'b1);
            look("R3 mid", base + 32'(sz / 2 + 3), 2'd2, 1'b0);
            if (c < 7) look("R3 beyond", base + 32'(sz), 2'd0, 1'b1);
        end

        // R4 translation ID
        wr(3'd0, 32'h5);
        put(10, 32'h2000_0040, 32'h4400_0300);
        wr(3'd0, 32'h6);
        look("R4 wrong pid", 32'h2000_0010, 2'd0, 1'b0);
        wr(3'd0, 32'h105);
        look("R4 pid match", 32'h2000_0010, 2'd0, 1'b0);
        wr(3'd0, 32'h0);

        // R5 priority
        put(21, 32'h3000_0040, 32'h5500_0300);
        put(20, 32'h3000_0040, 32'h6600_0300);
        look("R5 lowest", 32'h3000_0123, 2'd0, 1'b0);
        put(20, 32'h3000_0000, 32'h6600_0300);
        look("R5 next", 32'h3000_0123, 2'd0, 1'b0);

        // R7 R8 R9 permission sweep over zone 5
        put(30, 32'h4000_0040, 32'h7700_0050);
        for (int p = 0; p < 4; p++) begin
            put(30, 32'h4000_0040, 32'h7700_0050 | (32'(p) << 8));
            for (int z = 0; z < 4; z++) begin
                wr(3'd1, 32'(z) << 20);
                for (int u = 0; u < 2; u++)
                    for (int k = 0; k < 3; k++)
                        look(u ? "R8 user perm" : "R9 sup perm R7",
                             32'h4000_0200, 2'(k), 1'(u));
            end
        end

        // R10 search
        wr(3'd5, 32'h3000_0010);
        cfg_sel = 3'd2; #0.1; check("R10 search hit", cfg_rdata, 32'd21);
        wr(3'd5, 32'hF000_0000);
        cfg_sel = 3'd2; #0.1; check("R10 search miss", cfg_rdata, 32'h8000_0000);
        wr(3'd5, 32'h0500_0000);
        cfg_sel = 3'd2; #0.1; check("R10 search size", cfg_rdata, 32'd4);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R11 watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule